// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction fetch address for a program store of one 512-word page. A decoder outside the block presents one-cycle control strobes for the current instruction: a plain jump, a subroutine call, a return, and three kinds of register-file write that land on the program counter. These writes are an add of the accumulator, a move of the accumulator, and a generic data write. When no strobe is active the address advances by one, wrapping at the end of the page.

Calls save their return address in a five-entry circular hardware stack, and returns take it back. Every data write to the counter clears address bit 8, so computed jumps reach only the lower 256 words. Every non-sequential load raises a one-cycle flush strobe. During that cycle the pipeline discards the instruction it had prefetched. The counter holds still, and the block ignores whatever strobes the squashed instruction presents.

Top module: `pc_sequencer`

## Requirements
- R1: While rstN is low and after it is released, pcAddr is 0 and flushStb is 0. All five stack slots hold 0, so a return issued before any call loads address 0.
- R2: In a cycle with flushStb low and no strobe active, pcAddr becomes (pcAddr + 1) mod 512 at the next clock edge.
- R3: jumpEn loads pcAddr with the full 9-bit targetAddr at the next edge.
- R4: callEn loads pcAddr with targetAddr and pushes (pcAddr + 1) mod 512 onto the stack. The push writes the slot at the stack pointer, and the pointer then advances by one, modulo 5.
- R5: retEn moves the stack pointer back by one, modulo 5, and loads pcAddr from the slot it then indexes. Nested calls therefore return in last-in, first-out order.
- R6: addAccEn loads pcAddr with bit 8 equal to 0 and bits 7:0 equal to ((pcAddr + 1) mod 256 + accVal) mod 256.
- R7: movAccEn loads pcAddr with bit 8 equal to 0 and bits 7:0 equal to accVal.
- R8: regWrEn loads pcAddr with bit 8 equal to 0 and bits 7:0 equal to regWrData.
- R9: Every load of R3 to R8 sets flushStb high for exactly the next cycle. During that cycle pcAddr holds its value, all strobes are ignored, and the stack is left unchanged.
- R10: When several strobes are high together, only one acts. The order of precedence is call, jump, return, add, move, generic write.
- R11: The stack never signals an error. A sixth push without a return in between overwrites the oldest entry. Returns keep walking round the five slots whatever the count of pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| jumpEn | input | 1 | Plain jump strobe |
| callEn | input | 1 | Subroutine call strobe |
| retEn | input | 1 | Return strobe, covering plain, literal and interrupt returns |
| addAccEn | input | 1 | Add accumulator to counter |
| movAccEn | input | 1 | Move accumulator into counter |
| regWrEn | input | 1 | Generic register write to counter |
| targetAddr | input | 9 | Address field of jump or call |
| accVal | input | 8 | Accumulator value |
| regWrData | input | 8 | Result data of a generic write |
| pcAddr | output | 9 | Current instruction address |
| flushStb | output | 1 | One-cycle flush strobe that inserts the extra cycle |

## Verification
The main sequencing is tried with sparse random strobes that rarely coincide, which shows that each load source and its flush cycle work alone. It is also tried with dense random strobes that often coincide, which separates a correct precedence order from a wrong one. Directed sequences check two stack cases: six nested calls unwound by seven returns, which shows the wrap-around overwrite, and a return straight after reset. Further directed cases cover address wrap at 511, an 8-bit carry in the accumulator add that must not reach bit 8, and strobes held high during the flush cycle, which must leave the counter unmoved.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  typedef enum logic [2:0] {
    SEL_INC,
    SEL_HOLD,
    SEL_TARGET,
    SEL_STACK,
    SEL_ADD,
    SEL_MOV,
    SEL_REG
  } pcSel_e;

  typedef struct packed {
    pcSel_e sel;
    logic   push;
    logic   pop;
  } pcStrobe_t;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      jumpEn,
  input  logic      callEn,
  input  logic      retEn,
  input  logic      addAccEn,
  input  logic      movAccEn,
  input  logic      regWrEn,
  output pcStrobe_t strobe,
  output logic      flushStb
);

  logic loadNext;

  // Precedence: call, jump, return, add, move, generic write.
  always_comb begin
    strobe.sel  = SEL_INC;
    strobe.push = 1'b0;
    strobe.pop  = 1'b0;
    if (flushStb) begin
      strobe.sel = SEL_HOLD;
    end else if (callEn) begin
      strobe.sel  = SEL_TARGET;
      strobe.push = 1'b1;
    end else if (jumpEn) begin
      strobe.sel = SEL_TARGET;
    end else if (retEn) begin
      strobe.sel = SEL_STACK;
      strobe.pop = 1'b1;
    end else if (addAccEn) begin
      strobe.sel = SEL_ADD;
    end else if (movAccEn) begin
      strobe.sel = SEL_MOV;
    end else if (regWrEn) begin
      strobe.sel = SEL_REG;
    end
  end

  assign loadNext = (strobe.sel != SEL_INC) && (strobe.sel != SEL_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN) flushStb <= 1'b0;
    else       flushStb <= loadNext;
  end

endmodule

// File: rtl/pc_seq_dpath.sv
module pc_seq_dpath
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] regWrData,
  output logic [ADDR_W-1:0] pcAddr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] stackMem [DEPTH];
  logic [PTR_W-1:0]  ptr, ptrPrev, ptrNext;
  logic [ADDR_W-1:0] pcPlusOne, nextPc;
  logic [DATA_W-1:0] addLow;

  assign ptrPrev   = (ptr == '0)   ? LAST : ptr - 1'b1;
  assign ptrNext   = (ptr == LAST) ? '0   : ptr + 1'b1;
  assign pcPlusOne = pcAddr + 1'b1;
  assign addLow    = pcPlusOne[DATA_W-1:0] + accVal;

  always_comb begin
    unique case (strobe.sel)
      SEL_HOLD:   nextPc = pcAddr;
      SEL_TARGET: nextPc = targetAddr;
      SEL_STACK:  nextPc = stackMem[ptrPrev];
      SEL_ADD:    nextPc = {{HI_W{1'b0}}, addLow};
      SEL_MOV:    nextPc = {{HI_W{1'b0}}, accVal};
      SEL_REG:    nextPc = {{HI_W{1'b0}}, regWrData};
      default:    nextPc = pcPlusOne;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcAddr <= '0;
      ptr    <= '0;
    end else begin
      pcAddr <= nextPc;
      if (strobe.push)     ptr <= ptrNext;
      else if (strobe.pop) ptr <= ptrPrev;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                                  stackMem[i] <= '0;
      else if (strobe.push && ptr == PTR_W'(i))   stackMem[i] <= pcPlusOne;
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              jumpEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              addAccEn,
  input  logic              movAccEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] regWrData,
  output logic [ADDR_W-1:0] pcAddr,
  output logic              flushStb
);

  pcStrobe_t strobe;

  pc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn),
    .addAccEn(addAccEn), .movAccEn(movAccEn), .regWrEn(regWrEn),
    .strobe(strobe), .flushStb(flushStb)
  );

  pc_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .targetAddr(targetAddr), .accVal(accVal), .regWrData(regWrData),
    .pcAddr(pcAddr)
  );

endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              jumpEn,
  input logic              callEn,
  input logic              retEn,
  input logic              addAccEn,
  input logic              movAccEn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] targetAddr,
  input logic [DATA_W-1:0] accVal,
  input logic [DATA_W-1:0] regWrData,
  input logic [ADDR_W-1:0] pcAddr,
  input logic              flushStb
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic anyEn;
  assign anyEn = jumpEn | callEn | retEn | addAccEn | movAccEn | regWrEn;

  // R1
  reset_state_chk: assert property (@(posedge clk) !rstN |=> (pcAddr == '0 && !flushStb));

  // R2
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushStb && !anyEn) |=> (pcAddr == $past(pcAddr) + 1'b1 && !flushStb));

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushStb && jumpEn && !callEn) |=> (pcAddr == $past(targetAddr) && flushStb));

  // R4
  call_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushStb && callEn) |=> (pcAddr == $past(targetAddr) && flushStb));

  // R7
  mov_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushStb && movAccEn && !jumpEn && !callEn && !retEn && !addAccEn)
    |=> (pcAddr == {{HI_W{1'b0}}, $past(accVal)}));

  // R8
  reg_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushStb && regWrEn && !jumpEn && !callEn && !retEn && !addAccEn && !movAccEn)
    |=> (pcAddr == {{HI_W{1'b0}}, $past(regWrData)}));

  // R6
  add_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushStb && addAccEn && !jumpEn && !callEn && !retEn) |=> (pcAddr[ADDR_W-1] == 1'b0));

  // R9
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |=> ($stable(pcAddr) && !flushStb));

endmodule

bind pc_sequencer pc_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn),
  .addAccEn(addAccEn), .movAccEn(movAccEn), .regWrEn(regWrEn),
  .targetAddr(targetAddr), .accVal(accVal), .regWrData(regWrData),
  .pcAddr(pcAddr), .flushStb(flushStb)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       jumpEn = 0, callEn = 0, retEn = 0, addAccEn = 0, movAccEn = 0, regWrEn = 0;
  logic [8:0] targetAddr = '0;
  logic [7:0] accVal = '0, regWrData = '0;
  logic [8:0] pcAddr;
  logic       flushStb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [8:0] mPc;
  logic       mFlush;
  logic [8:0] mStk [5];
  int         mSp;

  always #2 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rstN(rstN),
    .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn),
    .addAccEn(addAccEn), .movAccEn(movAccEn), .regWrEn(regWrEn),
    .targetAddr(targetAddr), .accVal(accVal), .regWrData(regWrData),
    .pcAddr(pcAddr), .flushStb(flushStb)
  );

  function automatic string reqOf();
    int n;
    n = jumpEn + callEn + retEn + addAccEn + movAccEn + regWrEn;
    if (mFlush)   return "R9";
    if (n > 1)    return "R10";
    if (callEn)   return "R4";
    if (jumpEn)   return "R3";
    if (retEn)    return "R5";
    if (addAccEn) return "R6";
    if (movAccEn) return "R7";
    if (regWrEn)  return "R8";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [8:0] expPc, input logic expFl);
    checks++;
    if (pcAddr !== expPc || flushStb !== expFl) begin
      fails++;
      $display("FAIL %s: pcAddr=%0d flushStb=%0b expected pcAddr=%0d flushStb=%0b",
               req, pcAddr, flushStb, expPc, expFl);
    end
  endtask

  // Reference model step for the strobes currently driven.
  task automatic modelStep();
    logic [8:0] nPc;
    logic       nFl;
    nFl = 1'b1;
    if (mFlush) begin
      nPc = mPc; nFl = 1'b0;
    end else if (callEn) begin
      mStk[mSp] = mPc + 9'd1; mSp = (mSp + 1) % 5; nPc = targetAddr;
    end else if (jumpEn) begin
      nPc = targetAddr;
    end else if (retEn) begin
      mSp = (mSp + 4) % 5; nPc = mStk[mSp];
    end else if (addAccEn) begin
      nPc = {1'b0, 8'(mPc[7:0] + 8'd1 + accVal)};
    end else if (movAccEn) begin
      nPc = {1'b0, accVal};
    end else if (regWrEn) begin
      nPc = {1'b0, regWrData};
    end else begin
      nPc = mPc + 9'd1; nFl = 1'b0;
    end
    mPc = nPc; mFlush = nFl;
  endtask

  task automatic step(input bit j, input bit c, input bit r, input bit a, input bit m,
                      input bit w, input logic [8:0] t, input logic [7:0] acc,
                      input logic [7:0] d, input string tag);
    string req;
    jumpEn = j; callEn = c; retEn = r; addAccEn = a; movAccEn = m; regWrEn = w;
    targetAddr = t; accVal = acc; regWrData = d;
    req = (tag != "") ? tag : reqOf();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check(req, mPc, mFlush);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, '0, '0, '0, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    jumpEn = 0; callEn = 0; retEn = 0; addAccEn = 0; movAccEn = 0; regWrEn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mPc = '0; mFlush = 1'b0; mSp = 0;
    for (int i = 0; i < 5; i++) mStk[i] = '0;
    check("R1", 9'd0, 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();

    // R1: return straight after reset loads address 0
    step(0, 0, 1, 0, 0, 0, '0, '0, '0, "R1");
    idle("R9");

    // R2: wrap at end of page
    step(1, 0, 0, 0, 0, 0, 9'd510, '0, '0, "R3");
    idle("R9");
    idle("R2");
    idle("R2");

    // R9: strobes during flush are ignored, counter holds
    step(1, 0, 0, 0, 0, 0, 9'd300, '0, '0, "R3");
    step(1, 1, 1, 1, 1, 1, 9'd77, 8'd5, 8'd9, "R9");
    idle("R2");

    // R6: carry out of the low byte must not reach bit 8
    step(1, 0, 0, 0, 0, 0, 9'd254, '0, '0, "R3");
    idle("R9");
    step(0, 0, 0, 1, 0, 0, '0, 8'd3, '0, "R6");
    idle("R9");
    step(1, 0, 0, 0, 0, 0, 9'd400, '0, '0, "R3");
    idle("R9");
    step(0, 0, 0, 0, 1, 0, '0, 8'd200, '0, "R7");
    idle("R9");
    step(0, 0, 0, 0, 0, 1, '0, '0, 8'd17, "R8");
    idle("R9");

    // R4/R11: call at 511 pushes 0; six nested calls then seven returns
    step(1, 0, 0, 0, 0, 0, 9'd511, '0, '0, "R3");
    idle("R9");
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 0, 0, 0, 0, 9'(100 + 40 * i), '0, '0, "R4");
      idle("R9");
    end
    for (int i = 0; i < 7; i++) begin
      step(0, 0, 1, 0, 0, 0, '0, '0, '0, (i < 5) ? "R5" : "R11");
      idle("R9");
    end

    // R10: coincident strobes
    step(1, 1, 0, 0, 0, 0, 9'd33, '0, '0, "R10");
    idle("R9");
    step(0, 0, 1, 1, 1, 1, '0, 8'd1, 8'd2, "R10");
    idle("R9");
    step(0, 0, 0, 1, 1, 1, '0, 8'd4, 8'd2, "R10");
    idle("R9");

    // Sparse random mix
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 10) == 0,
           ($urandom % 14) == 0, ($urandom % 14) == 0, ($urandom % 14) == 0,
           9'($urandom), 8'($urandom), 8'($urandom), "");
    end
    // Dense random mix
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
           9'($urandom), 8'($urandom), 8'($urandom), "");
    end

    // Reset in mid-run clears everything again
    doReset();
    step(0, 0, 1, 0, 0, 0, '0, '0, '0, "R1");
    idle("R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule